// File: doc/BRIEF.md
# Scanline-Clocked Interrupt Counter

This block counts rendered display lines and raises an interrupt request to the processor once a programmed number of them has passed. Software programs it through four decoded write commands: load the running count directly, load a reload value, clear (copy the reload value into the count, disarm and drop the request), and arm. The display timing logic supplies a one-cycle horizontal-sync pulse together with three qualifiers (line is in the visible range, background drawing on, sprite drawing on), and a one-cycle vertical-sync pulse at each frame boundary.

The count steps down only on a qualified line while the block is armed and the count is above zero. When a step takes the count from one to zero, the count is refilled from the reload value in the same edge and the interrupt request is set. The request stays high until software issues the clear command. The arm/disarm behaviour is held in a two-state machine: `ST_IDLE` and `ST_ARMED`. Transition `T_ARM` (ST_IDLE to ST_ARMED) is taken on an arm command while the count is nonzero; transition `T_DISARM` (ST_ARMED to ST_IDLE) is taken on a clear command. Every other case holds the state.

The running count is brought out on `line_count` so that the system can see how many qualified lines remain.

Top module: `scanline_irq_counter`

## Requirements
- R1: A write with `wr_sel` = 0 loads `wr_data` into the running count; `line_count` shows it one cycle after the write edge.
- R2: A write with `wr_sel` = 1 loads `wr_data` into the reload value and leaves the running count unchanged.
- R3: A write with `wr_sel` = 2 copies the reload value into the running count, moves the machine to ST_IDLE and clears `irq`.
- R4: A write with `wr_sel` = 3 moves the machine to ST_ARMED only if the running count is nonzero at that edge; with a zero count it has no effect.
- R5: On a `hsync` pulse the count decrements only when armed, `line_visible`, `bg_on` and `spr_on` are all 1, and the count is above zero; otherwise it holds.
- R6: A qualified step from a count of 1 refills the count from the reload value and sets `irq`, both visible one cycle after the edge.
- R7: A `vsync` pulse copies the reload value into the running count; when `vsync` and `hsync` coincide, the reload wins and no step happens.
- R8: After reset the count, the reload value and `irq` are 0 and the machine is in ST_IDLE.
- R9: Once set, `irq` stays 1 until a clear command (`wr_sel` = 2) or reset.
- R10: When a write and a sync pulse arrive in the same cycle, the write is applied and the sync pulse is ignored for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Processor write strobe, one cycle per write |
| wr_sel | input | 2 | Decoded command: 0 count, 1 reload, 2 clear, 3 arm |
| wr_data | input | CNT_W | Write data |
| hsync | input | 1 | One-cycle pulse at each line end |
| line_visible | input | 1 | Current line lies in the visible range |
| bg_on | input | 1 | Background drawing enabled |
| spr_on | input | 1 | Sprite drawing enabled |
| vsync | input | 1 | One-cycle pulse at each frame boundary |
| irq | output | 1 | Sticky interrupt request |
| line_count | output | CNT_W | Current running count |

## Verification
Every result of this block (the new count, the interrupt request and the arm state seen through later steps) is registered once, so it is due exactly one cycle after the rising edge that samples the write or sync pulse. The driver applies one cycle of inputs at the falling edge and pushes the expected count and request for that cycle, computed from the requirements, into a queue; the monitor pops one item one nanosecond after every rising edge, so each comparison lands on the first cycle the result is valid and never on the edge itself. Directed sequences cover each qualifier held low, arming on a zero count, sync and write collisions and vertical reload mid-count, followed by a pseudo-random stretch.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

    localparam int unsigned SEL_W = 2;
    localparam int unsigned N_CMD = 4;

    // Decoded command codes on wr_sel
    localparam logic [SEL_W-1:0] SEL_LOAD_CNT = 2'd0;
    localparam logic [SEL_W-1:0] SEL_LOAD_REL = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CLEAR    = 2'd2;
    localparam logic [SEL_W-1:0] SEL_ARM      = 2'd3;

    typedef struct packed {
        logic arm;
        logic clear;
        logic load_rel;
        logic load_cnt;
    } sirq_cmd_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } sirq_state_t;

endpackage

// File: rtl/sirq_cmd_decode.sv
module sirq_cmd_decode
    import scanline_irq_pkg::*;
(
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    output sirq_cmd_t        cmd,
    output logic             any_write
);

    logic [N_CMD-1:0] hit;

    for (genvar g = 0; g < N_CMD; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_sel == SEL_W'(g));
    end

    always_comb begin
        cmd.load_cnt = hit[SEL_LOAD_CNT];
        cmd.load_rel = hit[SEL_LOAD_REL];
        cmd.clear    = hit[SEL_CLEAR];
        cmd.arm      = hit[SEL_ARM];
        any_write    = |hit;
    end

endmodule

// File: rtl/sirq_line_gate.sv
module sirq_line_gate (
    input  logic hsync,
    input  logic vsync,
    input  logic any_write,
    input  logic line_visible,
    input  logic bg_on,
    input  logic spr_on,
    output logic step_req,
    output logic frame_req
);

    logic drawing;

    always_comb begin
        drawing   = line_visible && bg_on && spr_on;
        // A write in the same cycle masks both sync actions
        frame_req = vsync && !any_write;
        step_req  = hsync && drawing && !any_write && !vsync;
    end

endmodule

// File: rtl/sirq_arm_fsm.sv
module sirq_arm_fsm
    import scanline_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sirq_cmd_t cmd,
    input  logic      count_nz,
    output logic      armed
);

    sirq_state_t state_q;
    sirq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd.arm && count_nz) state_d = ST_ARMED;   // T_ARM
            end
            ST_ARMED: begin
                if (cmd.clear) state_d = ST_IDLE;              // T_DISARM
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        armed = (state_q == ST_ARMED);
    end

endmodule

// File: rtl/sirq_counter.sv
module sirq_counter
    import scanline_irq_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sirq_cmd_t        cmd,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             armed,
    input  logic             step_req,
    input  logic             frame_req,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             count_nz,
    output logic             irq_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic do_step;
    logic expire;

    always_comb begin
        count_nz = (count_q != '0);
        do_step  = step_req && armed && count_nz;
        expire   = do_step && (count_q == ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            if (cmd.load_rel) reload_q <= wr_data;
            if (cmd.load_cnt)      count_q <= wr_data;
            else if (cmd.clear)    count_q <= reload_q;
            else if (frame_req)    count_q <= reload_q;
            else if (expire)       count_q <= reload_q;
            else if (do_step)      count_q <= count_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          irq_q <= 1'b0;
        else if (cmd.clear)  irq_q <= 1'b0;
        else if (expire)     irq_q <= 1'b1;
    end

endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
    import scanline_irq_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             hsync,
    input  logic             line_visible,
    input  logic             bg_on,
    input  logic             spr_on,
    input  logic             vsync,
    output logic             irq,
    output logic [CNT_W-1:0] line_count
);

    sirq_cmd_t        cmd;
    logic             any_write;
    logic             step_req;
    logic             frame_req;
    logic             armed;
    logic             count_nz;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_q;
    logic             irq_q;

    sirq_cmd_decode u_dec (
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .cmd       (cmd),
        .any_write (any_write)
    );

    sirq_line_gate u_gate (
        .hsync        (hsync),
        .vsync        (vsync),
        .any_write    (any_write),
        .line_visible (line_visible),
        .bg_on        (bg_on),
        .spr_on       (spr_on),
        .step_req     (step_req),
        .frame_req    (frame_req)
    );

    sirq_arm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .count_nz (count_nz),
        .armed    (armed)
    );

    sirq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .wr_data   (wr_data),
        .armed     (armed),
        .step_req  (step_req),
        .frame_req (frame_req),
        .count_q   (count_q),
        .reload_q  (reload_q),
        .count_nz  (count_nz),
        .irq_q     (irq_q)
    );

    assign irq        = irq_q;
    assign line_count = count_q;

endmodule

// File: rtl/scanline_irq_counter_chk.sv
module scanline_irq_counter_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             hsync,
    input logic             vsync,
    input logic             irq,
    input logic [CNT_W-1:0] line_count,
    input logic [CNT_W-1:0] reload_q,
    input logic             armed
);

    assert_load_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (line_count == $past(wr_data)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> (!irq && !armed && line_count == $past(reload_q)));

    assert_arm_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3 && line_count == '0 && !armed) |=> !armed);

    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(hsync) && $past(line_count) == CNT_W'(1)));

    assert_frame_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && vsync) |=> (line_count == $past(reload_q)));

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && wr_sel == 2'd2)) |=> irq);

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && (hsync || vsync)) |=> $stable(line_count));

endmodule

bind scanline_irq_counter scanline_irq_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .hsync      (hsync),
    .vsync      (vsync),
    .irq        (irq),
    .line_count (line_count),
    .reload_q   (reload_q),
    .armed      (armed)
);

// File: tb/scanline_irq_counter_test.sv
`timescale 1ns/1ps
module scanline_irq_counter_test;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             hsync = 1'b0, line_visible = 1'b0, bg_on = 1'b0, spr_on = 1'b0, vsync = 1'b0;
    logic             irq;
    logic [CNT_W-1:0] line_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Requirement-level reference state
    logic [CNT_W-1:0] m_cnt = '0, m_rel = '0;
    bit m_en = 0, m_irq = 0;

    logic [CNT_W-1:0] q_cnt[$];
    bit               q_irq[$];
    string            q_tag[$];

    always #2 clk = ~clk;

    scanline_irq_counter #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .hsync(hsync), .line_visible(line_visible), .bg_on(bg_on), .spr_on(spr_on),
        .vsync(vsync), .irq(irq), .line_count(line_count)
    );

    task automatic check(input string tag, input logic [CNT_W-1:0] exp_c, input bit exp_i);
        n_cmp++;
        if (line_count !== exp_c || irq !== exp_i) begin
            n_bad++;
            $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b",
                     tag, line_count, irq, exp_c, exp_i);
        end
    endtask

    // Driver: one cycle of inputs, expected result pushed to the scoreboard
    task automatic step(input bit w, input logic [1:0] s, input logic [CNT_W-1:0] d,
                        input bit hs, input bit vis, input bit bg, input bit sp,
                        input bit vs, input string tag);
        @(negedge clk);
        wr_en = w; wr_sel = s; wr_data = d;
        hsync = hs; line_visible = vis; bg_on = bg; spr_on = sp; vsync = vs;
        if (w) begin
            case (s)
                2'd0: m_cnt = d;                                  // R1
                2'd1: m_rel = d;                                  // R2
                2'd2: begin m_cnt = m_rel; m_en = 0; m_irq = 0; end // R3
                default: if (m_cnt != 0) m_en = 1;                // R4
            endcase
        end else if (vs) begin
            m_cnt = m_rel;                                        // R7
        end else if (hs && vis && bg && sp && m_en && m_cnt != 0) begin // R5
            if (m_cnt == 1) begin m_cnt = m_rel; m_irq = 1; end   // R6
            else m_cnt = m_cnt - 1;
        end
        q_cnt.push_back(m_cnt);
        q_irq.push_back(m_irq);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 2'd0, 8'd0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic line(input string tag);
        step(0, 2'd0, 8'd0, 1, 1, 1, 1, 0, tag);
    endtask

    task automatic wr(input logic [1:0] s, input logic [CNT_W-1:0] d, input string tag);
        step(1, s, d, 0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: each result is due one cycle after the sampling edge
    always @(posedge clk) begin
        #1;
        if (q_tag.size() != 0) begin
            logic [CNT_W-1:0] ec;
            bit ei;
            string t;
            ec = q_cnt.pop_front();
            ei = q_irq.pop_front();
            t  = q_tag.pop_front();
            check(t, ec, ei);
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 check("R8 reset", 8'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R8 idle after reset");

        // R1 / R2 / R6 / R9: basic countdown and sticky request
        wr(2'd1, 8'd3, "R2 load reload");
        wr(2'd0, 8'd2, "R1 load count");
        wr(2'd3, 8'd0, "R4 arm nonzero");
        line("R5 step 2->1");
        line("R6 expire reload");
        idle("R9 sticky");
        idle("R9 sticky");
        line("R5 step after expiry");

        // R3: clear drops request, disarms
        wr(2'd2, 8'd0, "R3 clear");
        for (int i = 0; i < 5; i++) line("R3 disarmed no step");

        // R4: arm ignored on zero count
        wr(2'd0, 8'd0, "R1 load zero");
        wr(2'd3, 8'd0, "R4 arm on zero ignored");
        wr(2'd0, 8'd1, "R1 load one");
        line("R4 not armed no irq");
        wr(2'd3, 8'd0, "R4 arm nonzero");
        line("R6 expire from one");

        // R5: each qualifier low blocks the step
        wr(2'd1, 8'd2, "R2 reload two");
        wr(2'd2, 8'd0, "R3 clear");
        wr(2'd3, 8'd0, "R4 arm");
        for (int i = 0; i < 3; i++) step(0, 2'd0, 8'd0, 1, 0, 1, 1, 0, "R5 invisible line");
        for (int i = 0; i < 3; i++) step(0, 2'd0, 8'd0, 1, 1, 0, 1, 0, "R5 background off");
        for (int i = 0; i < 3; i++) step(0, 2'd0, 8'd0, 1, 1, 1, 0, 0, "R5 sprites off");
        step(0, 2'd0, 8'd0, 0, 1, 1, 1, 0, "R5 no pulse");
        line("R5 step");
        line("R6 expire");

        // R7: frame reload mid-count and vsync over hsync
        wr(2'd1, 8'd4, "R2 reload four");
        wr(2'd2, 8'd0, "R3 clear");
        wr(2'd3, 8'd0, "R4 arm");
        line("R5 step");
        line("R5 step");
        step(0, 2'd0, 8'd0, 0, 0, 0, 0, 1, "R7 frame reload");
        step(0, 2'd0, 8'd0, 1, 1, 1, 1, 1, "R7 vsync beats hsync");
        for (int i = 0; i < 4; i++) line("R6 count to expiry");

        // R10: writes win over sync pulses
        wr(2'd2, 8'd0, "R3 clear");
        wr(2'd3, 8'd0, "R4 arm");
        step(1, 2'd1, 8'd7, 1, 1, 1, 1, 0, "R10 write beats hsync");
        step(1, 2'd0, 8'd9, 0, 0, 0, 0, 1, "R10 write beats vsync");
        step(0, 2'd0, 8'd0, 0, 0, 0, 0, 1, "R7 frame reload to seven");
        line("R5 step");

        // Mixed pseudo-random stretch
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'd0)
                step(1, lfsr[5:4], {5'd0, lfsr[8:6]}, lfsr[9], 1, 1, 1, lfsr[10] & lfsr[11], "R10 mixed write");
            else
                step(0, 2'd0, 8'd0, lfsr[4] | lfsr[5], lfsr[6] | lfsr[7], lfsr[8] | lfsr[9],
                     lfsr[10] | lfsr[11], (lfsr[15:12] == 4'hF), "R5 mixed sync");
        end

        idle("R9 drain");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule